// File: doc/BRIEF.md
# Priority Locality Arbiter

This block decides which of five privilege levels (localities 0 to 4) owns a shared coprocessor at any moment. Software at each locality talks to the block through one write port. Every write carries the writer's locality number and four write-one control bits. Through these bits a locality can ask for ownership, give it up, take it by force from a lower locality, or restore an "established" flag. The block keeps a set of pending requests. Whenever ownership is free and requests are waiting, it spends one cycle resolving and then grants the highest-numbered requester.

A shared state byte gives the result of arbitration. It holds a valid flag, an assigned flag, the encoded owner and the established flag. Each locality also has a two-bit status: granted, and a sticky been-seized flag. The established flag is cleared by a hash-end event input. It can only be set again from localities 3 or 4.

Top module: `loc_arbiter`

## Requirements
- R1: After reset the state byte reads 0x81: valid 1, established 1, nothing assigned. No locality is granted and no been-seized flag is set.
- R2: Control write data bits are: bit 0 request, bit 1 relinquish, bit 2 seize, bit 3 reset-establishment. A request written while nothing is owned makes valid read 0 for exactly the one cycle after the write. In the cycle after that, the requester is granted.
- R3: State byte layout is: bit 7 valid, bits 6:5 zero, bits 4:2 owner number (0 when unassigned), bit 1 assigned, bit 0 established. At most one locality is granted.
- R4: When the owner writes relinquish (bit 1) while requests are pending, one resolving cycle with valid 0 follows. After it, the highest-numbered pending locality is granted.
- R5: When the owner writes relinquish (bit 1) with nothing pending, the state becomes unassigned and valid stays 1.
- R6: A seize (bit 2) from a locality numbered higher than the owner moves ownership to the writer in the next cycle. The previous owner's been-seized flag is set and stays set.
- R7: A seize (bit 2) from a locality numbered equal to or lower than the owner has no effect. A seize made while nothing is owned also has no effect.
- R8: A locality's been-seized flag clears when that locality writes request (bit 0).
- R9: Relinquish (bit 1) from a locality that is not the owner withdraws that locality's pending request. A request (bit 0) from the current owner does not change ownership.
- R10: A hash-end pulse clears the established flag. Reset-establishment (bit 3) sets it again only when written from locality 3 or 4; from localities 0 to 2 it has no effect. Hash-end wins when both happen in the same cycle.
- R11: Writes tagged with locality numbers 5 to 7 change nothing.
- R12: When relinquish (bit 1) is set in a write, the seize and request bits of that same write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe, one write per cycle |
| wr_loc | input | 3 | Locality number of the writer |
| wr_data | input | 4 | Write-one control bits |
| hash_end | input | 1 | Pulse that clears the established flag |
| state_o | output | 8 | Shared state byte |
| granted_o | output | 5 | Per-locality granted flag |
| seized_o | output | 5 | Per-locality sticky been-seized flag |

## Verification
The assertions assume one control write per cycle. They also assume the locality tag stays within three bits and that hash_end is a plain level sampled at the clock, with no further protocol. The stimulus changes inputs only on the falling edge and gives each write for exactly one cycle. It sends out-of-range locality tags only in cycles where their lack of effect can be observed at the outputs. The been-seized assertion also relies on the owner register never holding a number above 4. No input can break this, because seizes and grants only ever load in-range localities.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    // control write bit positions
    localparam int CTL_REQ   = 0;
    localparam int CTL_REL   = 1;
    localparam int CTL_SEIZE = 2;
    localparam int CTL_ESTAB = 3;
    localparam int CTL_W     = 4;

    // state byte field positions
    localparam int ST_VALID  = 7;
    localparam int ST_OWN_HI = 4;
    localparam int ST_OWN_LO = 2;
    localparam int ST_ASSIGN = 1;
    localparam int ST_EST    = 0;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RESOLVE = 2'd1,
        PH_OWNED   = 2'd2
    } phase_e;

endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic [CTL_W-1:0]   wr_data,
    output logic [NUM_LOC-1:0] req_v,
    output logic [NUM_LOC-1:0] rel_v,
    output logic [NUM_LOC-1:0] seize_v,
    output logic [NUM_LOC-1:0] estab_v
);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        logic hit;
        assign hit        = wr_en && (wr_loc == LOC_W'(g));
        assign req_v[g]   = hit && wr_data[CTL_REQ];
        assign rel_v[g]   = hit && wr_data[CTL_REL];
        assign seize_v[g] = hit && wr_data[CTL_SEIZE];
        assign estab_v[g] = hit && wr_data[CTL_ESTAB];
    end

endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [NUM_LOC-1:0] vec,
    output logic [LOC_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (vec[i]) begin
                idx = LOC_W'(i);
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/loc_arb_estab.sv
module loc_arb_estab #(
    parameter int NUM_LOC   = 5,
    parameter int ESTAB_MIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hash_end,
    input  logic [NUM_LOC-1:0] estab_v,
    output logic               est_o
);

    logic est_d, est_q;
    logic high_hit;

    assign high_hit = |estab_v[NUM_LOC-1:ESTAB_MIN];

    always_comb begin
        est_d = est_q;
        if (hash_end) begin
            est_d = 1'b0;
        end else if (high_hit) begin
            est_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_q <= 1'b1;
        end else begin
            est_q <= est_d;
        end
    end

    assign est_o = est_q;

    AST_HASH_CLEARS_EST: assert property (@(posedge clk) disable iff (!rst_n)
        hash_end |=> !est_o); // R10

    AST_EST_SET_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(est_o) |-> $past(|estab_v[NUM_LOC-1:ESTAB_MIN])); // R10

endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int LOC_W     = 3,
    parameter int ESTAB_MIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic [3:0]         wr_data,
    input  logic               hash_end,
    output logic [7:0]         state_o,
    output logic [NUM_LOC-1:0] granted_o,
    output logic [NUM_LOC-1:0] seized_o
);

    localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

    typedef struct packed {
        phase_e             phase;
        logic [LOC_W-1:0]   owner;
        logic [NUM_LOC-1:0] req;
        logic [NUM_LOC-1:0] seized;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_LOC-1:0] req_v, rel_v, seize_v, estab_v;
    logic [NUM_LOC-1:0] req_w, seized_w;
    logic [LOC_W-1:0]   pick_idx;
    logic               pick_any;
    logic               owned, owner_rel, seize_ok, est;

    loc_arb_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_decode (
        .wr_en   (wr_en),
        .wr_loc  (wr_loc),
        .wr_data (wr_data),
        .req_v   (req_v),
        .rel_v   (rel_v),
        .seize_v (seize_v),
        .estab_v (estab_v)
    );

    loc_arb_estab #(.NUM_LOC(NUM_LOC), .ESTAB_MIN(ESTAB_MIN)) u_estab (
        .clk      (clk),
        .rst_n    (rst_n),
        .hash_end (hash_end),
        .estab_v  (estab_v),
        .est_o    (est)
    );

    assign owned = (st_q.phase == PH_OWNED);

    // pending-request and been-seized update from this cycle's write
    always_comb begin
        req_w     = st_q.req;
        seized_w  = st_q.seized;
        owner_rel = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rel_v[i]) begin
                req_w[i] = 1'b0;
                if (owned && st_q.owner == LOC_W'(i)) begin
                    owner_rel = 1'b1;
                end
            end else if (req_v[i]) begin
                seized_w[i] = 1'b0;
                if (!(owned && st_q.owner == LOC_W'(i))) begin
                    req_w[i] = 1'b1;
                end
            end
        end
        seize_ok = owned && (|seize_v) && !(|rel_v) && (wr_loc > st_q.owner);
    end

    loc_arb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
        .vec (req_w),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_comb begin
        st_d        = st_q;
        st_d.req    = req_w;
        st_d.seized = seized_w;
        case (st_q.phase)
            PH_IDLE: begin
                if (pick_any) begin
                    st_d.phase = PH_RESOLVE;
                end
            end
            PH_RESOLVE: begin
                if (pick_any) begin
                    st_d.phase = PH_OWNED;
                    st_d.owner = pick_idx;
                    for (int i = 0; i < NUM_LOC; i++) begin
                        if (pick_idx == LOC_W'(i)) begin
                            st_d.req[i] = 1'b0;
                        end
                    end
                end else begin
                    st_d.phase = PH_IDLE;
                end
            end
            PH_OWNED: begin
                if (owner_rel) begin
                    st_d.phase = pick_any ? PH_RESOLVE : PH_IDLE;
                    st_d.owner = '0;
                end else if (seize_ok) begin
                    for (int i = 0; i < NUM_LOC; i++) begin
                        if (st_q.owner == LOC_W'(i)) begin
                            st_d.seized[i] = 1'b1;
                        end
                        if (wr_loc == LOC_W'(i)) begin
                            st_d.req[i] = 1'b0;
                        end
                    end
                    st_d.owner = wr_loc;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.owner = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, owner: '0, req: '0, seized: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        state_o                     = '0;
        state_o[ST_VALID]           = (st_q.phase != PH_RESOLVE);
        state_o[ST_OWN_HI:ST_OWN_LO] = 3'(st_q.owner);
        state_o[ST_ASSIGN]          = owned;
        state_o[ST_EST]             = est;
        for (int i = 0; i < NUM_LOC; i++) begin
            granted_o[i] = owned && (st_q.owner == LOC_W'(i));
        end
    end

    assign seized_o = st_q.seized;

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(granted_o)); // R3

    AST_RESOLVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !state_o[ST_VALID] |=> state_o[ST_VALID]); // R2

    AST_UNASSIGNED_ZERO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !state_o[ST_ASSIGN] |-> (state_o[ST_OWN_HI:ST_OWN_LO] == 3'd0)); // R3

    AST_BAD_LOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_loc > LAST_LOC && state_o[ST_ASSIGN]) |=> $stable(granted_o)); // R11

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_chk
        AST_SEIZE_HITS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(seized_o[g]) |-> $past(granted_o[g])); // R6
    end

endmodule

// File: tb/loc_arbiter_bench.sv
`timescale 1ns/1ps
module loc_arbiter_bench;

    typedef struct {
        logic [7:0] st;
        logic [4:0] gr;
        logic [4:0] sz;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_loc = '0;
    logic [3:0] wr_data = '0;
    logic       hash_end = 1'b0;
    logic [7:0] state_o;
    logic [4:0] granted_o, seized_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    loc_arbiter u_loc_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_loc    (wr_loc),
        .wr_data   (wr_data),
        .hash_end  (hash_end),
        .state_o   (state_o),
        .granted_o (granted_o),
        .seized_o  (seized_o)
    );

    function automatic logic [7:0] mk(input bit v, input int own, input bit asg, input bit est);
        return {v, 2'b00, 3'(own), asg, est};
    endfunction

    task automatic push(input logic [7:0] st, input logic [4:0] gr, input logic [4:0] sz, input string tag);
        exp_t e;
        e.st = st; e.gr = gr; e.sz = sz; e.tag = tag;
        sb.push_back(e);
    endtask

    // called on a falling edge; one write occupies one cycle
    task automatic drive(input logic we, input logic [2:0] loc, input logic [3:0] d, input logic he);
        wr_en = we; wr_loc = loc; wr_data = d; hash_end = he;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; hash_end = 1'b0;
    endtask

    // monitor: compares each expected item shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (state_o !== e.st || granted_o !== e.gr || seized_o !== e.sz) begin
                    errors++;
                    $display("FAIL %s: actual state=%h granted=%b seized=%b expected state=%h granted=%b seized=%b",
                             e.tag, state_o, granted_o, seized_o, e.st, e.gr, e.sz);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(8'h81, 5'b00000, 5'b00000, "R1 reset state");
        // R2: request from idle, one resolving cycle then grant
        drive(1, 3'd1, 4'b0001, 0); push(mk(0,0,0,1), 5'b00000, 5'b00000, "R2 resolving cycle");
        drive(0, 3'd0, 4'b0000, 0); push(mk(1,1,1,1), 5'b00010, 5'b00000, "R2 grant loc1");
        drive(0, 3'd0, 4'b0000, 0); push(mk(1,1,1,1), 5'b00010, 5'b00000, "R3 owner held");
        drive(1, 3'd2, 4'b0001, 0); push(mk(1,1,1,1), 5'b00010, 5'b00000, "R3 pending loc2");
        drive(1, 3'd0, 4'b0001, 0); push(mk(1,1,1,1), 5'b00010, 5'b00000, "R3 pending loc0");
        // R4: relinquish with pending, highest wins
        drive(1, 3'd1, 4'b0010, 0); push(mk(0,0,0,1), 5'b00000, 5'b00000, "R4 resolving");
        drive(0, 3'd0, 4'b0000, 0); push(mk(1,2,1,1), 5'b00100, 5'b00000, "R4 highest pending");
        // R7: low or equal seize ignored
        drive(1, 3'd1, 4'b0100, 0); push(mk(1,2,1,1), 5'b00100, 5'b00000, "R7 lower seize");
        drive(1, 3'd2, 4'b0100, 0); push(mk(1,2,1,1), 5'b00100, 5'b00000, "R7 equal seize");
        // R6: higher seize
        drive(1, 3'd3, 4'b0100, 0); push(mk(1,3,1,1), 5'b01000, 5'b00100, "R6 seize by loc3");
        drive(0, 3'd0, 4'b0000, 0); push(mk(1,3,1,1), 5'b01000, 5'b00100, "R6 sticky seized");
        // R10: established flag
        drive(0, 3'd0, 4'b0000, 1); push(mk(1,3,1,0), 5'b01000, 5'b00100, "R10 hash clears");
        drive(1, 3'd2, 4'b1000, 0); push(mk(1,3,1,0), 5'b01000, 5'b00100, "R10 loc2 ignored");
        // R11: out-of-range tag
        drive(1, 3'd7, 4'b1111, 0); push(mk(1,3,1,0), 5'b01000, 5'b00100, "R11 loc7 ignored");
        drive(1, 3'd5, 4'b0101, 0); push(mk(1,3,1,0), 5'b01000, 5'b00100, "R11 loc5 ignored");
        drive(1, 3'd4, 4'b1000, 0); push(mk(1,3,1,1), 5'b01000, 5'b00100, "R10 loc4 sets");
        drive(1, 3'd3, 4'b1000, 1); push(mk(1,3,1,0), 5'b01000, 5'b00100, "R10 hash wins");
        drive(1, 3'd3, 4'b1000, 0); push(mk(1,3,1,1), 5'b01000, 5'b00100, "R10 loc3 sets");
        // R8: victim request clears seized
        drive(1, 3'd2, 4'b0001, 0); push(mk(1,3,1,1), 5'b01000, 5'b00000, "R8 seized cleared");
        // R9: non-owner relinquish withdraws, owner request no effect
        drive(1, 3'd2, 4'b0010, 0); push(mk(1,3,1,1), 5'b01000, 5'b00000, "R9 withdraw loc2");
        drive(1, 3'd3, 4'b0001, 0); push(mk(1,3,1,1), 5'b01000, 5'b00000, "R9 owner request");
        // R12: relinquish beats seize in one write
        drive(1, 3'd4, 4'b0110, 0); push(mk(1,3,1,1), 5'b01000, 5'b00000, "R12 seize dropped");
        // loc0 is still pending; loc2 was withdrawn
        drive(1, 3'd3, 4'b0010, 0); push(mk(0,0,0,1), 5'b00000, 5'b00000, "R9 resolving after withdraw");
        drive(0, 3'd0, 4'b0000, 0); push(mk(1,0,1,1), 5'b00001, 5'b00000, "R9 loc0 wins, loc2 withdrawn");
        // R5: relinquish with nothing pending
        drive(1, 3'd0, 4'b0010, 0); push(mk(1,0,0,1), 5'b00000, 5'b00000, "R5 released");
        drive(1, 3'd4, 4'b0100, 0); push(mk(1,0,0,1), 5'b00000, 5'b00000, "R7 seize unowned");
        drive(0, 3'd0, 4'b0000, 0); push(mk(1,0,0,1), 5'b00000, 5'b00000, "R7 no resolve");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule